// File: doc/BRIEF.md
# Serial Memory Write-Protection Unit

This unit holds the write-protection and status logic of a small serial nonvolatile byte memory with a 15-bit byte address. It keeps a write-enable latch, a two-bit block-protect code that fences off a region of the array, and a protect-enable bit. The protect-enable bit decides whether an active-low write-protect pin may lock the status register. The serial front end decodes commands and turns them into single-cycle event pulses. This unit turns those pulses, the target address and the pin level into two permissions: one for array writes and one for status writes. It also assembles the status byte that the front end shifts out on a status read.

The write-enable latch is armed by a completed write-enable command. It drops on a write-disable command or when chip select rises to end a write cycle, so each write needs its own enable. The pin level is captured only at the falling edge of chip select. A pin change in the middle of a transaction therefore has no effect until the next transaction begins. The block-protect code and the protect-enable bit come out of reset at parameter values that stand in for the stored nonvolatile state.

Top module: `wp_guard`

## Requirements
- R1: With the latch set, an array write to `addr` is refused when it falls in the region selected by block-protect code `sr_byte[3:2]`. Code 2'b00 protects nothing, 2'b01 protects 6000h–7FFFh, 2'b10 protects 4000h–7FFFh, and 2'b11 protects every address.
- R2: While the write-enable latch (`sr_byte[1]`) is 0, both `mem_wr_ok` and `sr_wr_ok` are 0 for any address and pin level.
- R3: With the latch set and the protect-enable bit (`sr_byte[7]`) 0, `sr_wr_ok` is 1 whatever the sampled pin level.
- R4: With the latch set and the protect-enable bit 1, `sr_wr_ok` equals the pin level sampled at the most recent chip-select fall. A sampled 0 locks the status register.
- R5: A `wdis_evt` or `wr_end_evt` pulse clears the latch on the next clock edge. A clear takes priority over a simultaneous `wen_evt`.
- R6: The pin level is captured only in a cycle with `cs_fall` high. Pin changes at any other time do not alter `sr_wr_ok`.
- R7: An `sr_wr_evt` pulse while `sr_wr_ok` is 1 loads `sr_wdata[7]` into the protect-enable bit and `sr_wdata[3:2]` into the block-protect code. Other data bits are ignored. When `sr_wr_ok` is 0, the pulse changes nothing.
- R8: A `wen_evt` pulse, without a clear in the same cycle, sets the latch on the next clock edge.
- R9: Status byte layout: bit 7 is protect-enable, bits 3:2 are the block-protect code, bit 1 is the latch, and bits 6:4 and 0 read 0. After reset the latch is 0, the protect fields hold `INIT_PEN`/`INIT_BP`, and the sampled pin reads as 0 (locked).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_fall | input | 1 | Pulse: chip select fell (start of a transaction) |
| wp_pin_n | input | 1 | Write-protect pin level, 0 = protect |
| wen_evt | input | 1 | Pulse: write-enable command completed |
| wdis_evt | input | 1 | Pulse: write-disable command decoded |
| sr_wr_evt | input | 1 | Pulse: status write data byte received |
| sr_wdata | input | 8 | Status write data byte |
| wr_end_evt | input | 1 | Pulse: chip select rose ending a write cycle |
| addr | input | 15 | Target byte address of an array write |
| mem_wr_ok | output | 1 | Array write to `addr` is permitted |
| sr_wr_ok | output | 1 | Status register write is permitted |
| sr_byte | output | 8 | Status byte for readback |

## Verification
The hardest state to reach is a status lock that depends on two stored facts at once. The protect-enable bit must have been written to 1 during an earlier enabled status write. The pin must have been sampled low at a chip-select fall, and it must have changed since without a new fall. The directed part of the bench builds this chain step by step: enable, write the status byte, end the cycle, re-enable, then toggle the pin with and without a chip-select fall. Random traffic then mixes all the pulses with random addresses and pin levels, and a reference model follows every state change.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  localparam int SR_W      = 8;
  localparam int PEN_BIT   = 7;
  localparam int BP_HI_BIT = 3;
  localparam int BP_LO_BIT = 2;
  localparam int WEL_BIT   = 1;

  typedef struct packed {
    logic       pen;
    logic [1:0] bp;
  } prot_cfg_t;

  function automatic logic [SR_W-1:0] pack_status(prot_cfg_t cfg, logic wel);
    logic [SR_W-1:0] s;
    s = '0;
    s[PEN_BIT]   = cfg.pen;
    s[BP_HI_BIT] = cfg.bp[1];
    s[BP_LO_BIT] = cfg.bp[0];
    s[WEL_BIT]   = wel;
    return s;
  endfunction
endpackage

// File: rtl/wpg_latch.sv
module wpg_latch (
  input  logic clk,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_a_i,
  input  logic clr_b_i,
  output logic wel_o
);
  logic wel_q, wel_d, wel_en;

  always_comb begin
    wel_en = set_i | clr_a_i | clr_b_i;
    wel_d  = ~(clr_a_i | clr_b_i);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     wel_q <= 1'b0;
    else if (wel_en) wel_q <= wel_d;
  end

  assign wel_o = wel_q;

  // R5: any clear pulse leaves the latch low next cycle
  a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_ni)
    (clr_a_i || clr_b_i) |=> !wel_o);
  // R8: enable without a clear sets the latch
  a_r8_enable_sets: assert property (@(posedge clk) disable iff (!rst_ni)
    (set_i && !clr_a_i && !clr_b_i) |=> wel_o);
endmodule

// File: rtl/wpg_status.sv
module wpg_status
  import wpg_pkg::*;
#(
  parameter logic [1:0] INIT_BP  = 2'b00,
  parameter logic       INIT_PEN = 1'b0
) (
  input  logic      clk,
  input  logic      rst_ni,
  input  logic      cs_fall_i,
  input  logic      pin_i,
  input  logic      wr_evt_i,
  input  logic      wr_ok_i,
  input  logic      new_pen_i,
  input  logic [1:0] new_bp_i,
  output prot_cfg_t cfg_o,
  output logic      pin_o
);
  prot_cfg_t cfg_q, cfg_d;
  logic      cfg_en;
  logic      pin_q;

  always_comb begin
    cfg_en     = wr_evt_i & wr_ok_i;
    cfg_d.pen  = new_pen_i;
    cfg_d.bp   = new_bp_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.pen <= INIT_PEN;
      cfg_q.bp  <= INIT_BP;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)        pin_q <= 1'b0;
    else if (cs_fall_i) pin_q <= pin_i;
  end

  assign cfg_o = cfg_q;
  assign pin_o = pin_q;

  // R6: sampled pin only moves at a chip-select fall
  a_r6_pin_held: assert property (@(posedge clk) disable iff (!rst_ni)
    !cs_fall_i |=> $stable(pin_o));
  // R7: a refused status write leaves the protect fields untouched
  a_r7_refused_no_change: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_evt_i && !wr_ok_i) |=> $stable(cfg_o));
endmodule

// File: rtl/wpg_region.sv
module wpg_region #(
  parameter int AW = 15
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    bp_i,
  output logic          hit_o
);
  logic top_half, top_quarter;

  generate
    if (AW >= 2) begin : g_wide
      assign top_half    = addr_i[AW-1];
      assign top_quarter = &addr_i[AW-1:AW-2];
    end else begin : g_narrow
      assign top_half    = addr_i[AW-1];
      assign top_quarter = addr_i[AW-1];
    end
  endgenerate

  always_comb begin
    unique case (bp_i)
      2'b00:   hit_o = 1'b0;
      2'b01:   hit_o = top_quarter;
      2'b10:   hit_o = top_half;
      default: hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wpg_pkg::*;
#(
  parameter int         ADDR_W   = 15,
  parameter logic [1:0] INIT_BP  = 2'b00,
  parameter logic       INIT_PEN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_fall,
  input  logic              wp_pin_n,
  input  logic              wen_evt,
  input  logic              wdis_evt,
  input  logic              sr_wr_evt,
  input  logic [SR_W-1:0]   sr_wdata,
  input  logic              wr_end_evt,
  input  logic [ADDR_W-1:0] addr,
  output logic              mem_wr_ok,
  output logic              sr_wr_ok,
  output logic [SR_W-1:0]   sr_byte
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_i;
  logic              wel;
  logic              pin_s;
  logic              in_region;
  prot_cfg_t         cfg;
  logic              unused_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_i = rst_sync_q[SYNC_N-1];

  wpg_latch u_latch (
    .clk     (clk),
    .rst_ni  (rst_i),
    .set_i   (wen_evt),
    .clr_a_i (wdis_evt),
    .clr_b_i (wr_end_evt),
    .wel_o   (wel)
  );

  wpg_status #(.INIT_BP(INIT_BP), .INIT_PEN(INIT_PEN)) u_status (
    .clk       (clk),
    .rst_ni    (rst_i),
    .cs_fall_i (cs_fall),
    .pin_i     (wp_pin_n),
    .wr_evt_i  (sr_wr_evt),
    .wr_ok_i   (sr_wr_ok),
    .new_pen_i (sr_wdata[PEN_BIT]),
    .new_bp_i  ({sr_wdata[BP_HI_BIT], sr_wdata[BP_LO_BIT]}),
    .cfg_o     (cfg),
    .pin_o     (pin_s)
  );

  wpg_region #(.AW(ADDR_W)) u_region (
    .addr_i (addr),
    .bp_i   (cfg.bp),
    .hit_o  (in_region)
  );

  always_comb begin
    mem_wr_ok = wel & ~in_region;
    sr_wr_ok  = wel & ~(cfg.pen & ~pin_s);
    sr_byte   = pack_status(cfg, wel);
  end

  assign unused_bits = ^{sr_wdata[6:4], sr_wdata[1:0]};

  // R2: no permission of either kind while the latch is low
  a_r2_locked_when_clear: assert property (@(posedge clk) disable iff (!rst_i)
    !sr_byte[WEL_BIT] |-> (!mem_wr_ok && !sr_wr_ok));
  // R1: code 11 refuses every array address
  a_r1_full_fence: assert property (@(posedge clk) disable iff (!rst_i)
    (sr_byte[BP_HI_BIT] && sr_byte[BP_LO_BIT]) |-> !mem_wr_ok);
  // R3: with protect-enable clear, status writes follow only the latch
  a_r3_pin_ignored: assert property (@(posedge clk) disable iff (!rst_i)
    (!sr_byte[PEN_BIT] && sr_byte[WEL_BIT]) |-> sr_wr_ok);
  // R9: unused status bits always read zero
  a_r9_spare_zero: assert property (@(posedge clk) disable iff (!rst_i)
    (sr_byte[6:4] == 3'b000) && !sr_byte[0]);
endmodule

// File: tb/sim_wp_guard.sv
module sim_wp_guard;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_fall, wp_pin_n, wen_evt, wdis_evt, sr_wr_evt, wr_end_evt;
  logic [7:0]  sr_wdata;
  logic [14:0] addr;
  logic        mem_wr_ok, sr_wr_ok;
  logic [7:0]  sr_byte;

  int checks = 0;
  int fails  = 0;

  logic       m_wel, m_pen, m_pin;
  logic [1:0] m_bp;

  always #5 clk = ~clk;

  wp_guard u0 (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .wp_pin_n(wp_pin_n),
    .wen_evt(wen_evt), .wdis_evt(wdis_evt), .sr_wr_evt(sr_wr_evt),
    .sr_wdata(sr_wdata), .wr_end_evt(wr_end_evt), .addr(addr),
    .mem_wr_ok(mem_wr_ok), .sr_wr_ok(sr_wr_ok), .sr_byte(sr_byte)
  );

  function automatic logic f_region(logic [1:0] bp, logic [14:0] a);
    case (bp)
      2'b00:   return 1'b0;
      2'b01:   return a >= 15'h6000;
      2'b10:   return a >= 15'h4000;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic f_mem_ok(logic wel, logic [1:0] bp, logic [14:0] a);
    return wel && !f_region(bp, a);
  endfunction

  function automatic logic f_sr_ok(logic wel, logic pen, logic pin);
    return wel && (!pen || pin);
  endfunction

  function automatic logic [7:0] f_byte(logic pen, logic [1:0] bp, logic wel);
    return {pen, 3'b000, bp, wel, 1'b0};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input logic fall, input logic pin,
                     input logic wen, input logic wdis, input logic srw,
                     input logic [7:0] d, input logic wend, input logic [14:0] a);
    logic e_sr;
    @(negedge clk);
    cs_fall = fall; wp_pin_n = pin; wen_evt = wen; wdis_evt = wdis;
    sr_wr_evt = srw; sr_wdata = d; wr_end_evt = wend; addr = a;
    #1;
    e_sr = f_sr_ok(m_wel, m_pen, m_pin);
    chk({tag, " mem_wr_ok"}, {7'd0, mem_wr_ok}, {7'd0, f_mem_ok(m_wel, m_bp, a)});
    chk({tag, " sr_wr_ok"},  {7'd0, sr_wr_ok},  {7'd0, e_sr});
    chk({tag, " sr_byte"},   sr_byte, f_byte(m_pen, m_bp, m_wel));
    @(posedge clk);
    if (srw && e_sr) begin m_pen = d[7]; m_bp = d[3:2]; end
    if (fall) m_pin = pin;
    if (wdis || wend) m_wel = 1'b0;
    else if (wen)     m_wel = 1'b1;
  endtask

  task automatic idle(input string tag, input logic pin, input logic [14:0] a);
    cyc(tag, 1'b0, pin, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, a);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    cs_fall = 0; wp_pin_n = 1; wen_evt = 0; wdis_evt = 0; sr_wr_evt = 0;
    sr_wdata = 0; wr_end_evt = 0; addr = 0;
    m_wel = 0; m_pen = 1'b0; m_bp = 2'b00; m_pin = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);

    // R9: reset state, spare bits zero, latch clear
    idle("R9 reset", 1'b1, 15'h7FFF);
    // R2: nothing allowed with latch clear, even a status write attempt
    cyc("R2", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'hFF, 1'b0, 15'h0000);
    idle("R2 no change", 1'b1, 15'h0000);
    // R8: enable sets latch
    cyc("R8", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 15'h1234);
    idle("R8 set", 1'b1, 15'h1234);
    // R3: pen clear, sampled pin low (from reset) ignored
    idle("R3", 1'b0, 15'h0000);
    // R7: write 0x73 -> pen 0, bp 00 (bits 6:4,1,0 ignored)
    cyc("R7 ignore bits", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h73, 1'b0, 15'h0);
    idle("R7 ignore bits", 1'b1, 15'h0);
    // R1: walk each code
    for (int c = 1; c < 4; c++) begin
      cyc("R7 bp load", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, {6'b0, 2'(c)} << 2, 1'b0, 15'h0);
      idle("R1 5FFF", 1'b1, 15'h5FFF);
      idle("R1 6000", 1'b1, 15'h6000);
      idle("R1 3FFF", 1'b1, 15'h3FFF);
      idle("R1 4000", 1'b1, 15'h4000);
      idle("R1 0000", 1'b1, 15'h0000);
    end
    // R7: set pen with bp 00, then end cycle clears latch (R5)
    cyc("R7 pen", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h80, 1'b0, 15'h0);
    cyc("R5 end", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 15'h0);
    idle("R5 cleared", 1'b1, 15'h0);
    // R5: clear beats simultaneous enable
    cyc("R5 prio", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 15'h0);
    idle("R5 prio", 1'b1, 15'h0);
    // R4: pen set, pin sampled 0 since reset -> locked
    cyc("R8 re", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 15'h0);
    cyc("R4 locked", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h0C, 1'b0, 15'h0);
    idle("R4 locked no change", 1'b1, 15'h0);
    // R6: pin high without fall: still locked
    idle("R6 no fall", 1'b1, 15'h0);
    // R4: fall samples high -> writable
    cyc("R4 sample", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 15'h0);
    idle("R4 open", 1'b0, 15'h0);
    idle("R6 mid change", 1'b0, 15'h0);
    // R4: fall samples low -> locked again
    cyc("R4 sample low", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 15'h0);
    idle("R4 relocked", 1'b1, 15'h0);
    // R5: write-disable clears
    cyc("R5 wdis", 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 15'h0);
    idle("R5 wdis", 1'b1, 15'h0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      cyc("R1 R2 R3 R4 R5 R6 R7 R8 random",
          ($urandom % 4) == 0, $urandom % 2, ($urandom % 3) == 0,
          ($urandom % 12) == 0, ($urandom % 4) == 0, 8'($urandom),
          ($urandom % 9) == 0, 15'($urandom));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule